// File: doc/BRIEF.md
# Exponential-Domain Stochastic Adder

This block sums several stochastic bit streams, each carrying a probability as its density of ones, into a single output stream. A random multiplexer adder has to scale the sum down by the input count, so its output needs a much longer observation window to reach the same precision. This block avoids that scaling.

Each input stream is first mapped to a stream whose density approximates exp(-x). The mapped streams are then combined with one wide AND gate. For independent streams the AND forms the product, and a product of exp(-x_i) terms equals exp of minus the sum. The complement z of the product density is mapped back to a sum with a second-order logarithm approximation, z + z^2/2 (the circuit realises z + (1-z)·z^2/2). The squared terms come from delayed copies of a stream, which are independent of the current bit when the stream's bits are independent. Each squared term is halved by one external random bit. The caller supplies one fair random bit per input and one more for the logarithm stage. The result is meant for sums inside [0,1]. Larger sums give an output density near one.

Top module: `sadd_exp_top`

## Requirements
- R1: While `rst_n` is low, `sum_bit` reads 0 whatever the inputs. All internal delay lines restart from zero, so the first cycles after reset behave as if every earlier input bit had been 0.
- R2: For each input i, the mapped bit is e_i(t) = NOT( x_i(t) AND NOT( x_i(t-1) AND rnd_half_i(t) ) ). Here x_i(t-1) is input i's bit from the previous cycle. An input held at 1 with its random bit at 1 therefore yields e_i = 1 from its second cycle on.
- R3: The complement bit z(t) is 1 exactly when at least one mapped bit e_i(t) is 0.
- R4: `sum_bit` at cycle t+1 equals z(t) OR ( z(t-GAP) AND z(t-2·GAP) AND rnd_log(t) ).
- R5: If every input bit has been 0 in the current cycle and in the 2·GAP cycles before it (cycles since reset count as 0), `sum_bit` is 0 in the next cycle, whatever the random bits.
- R6: Take independent input streams whose densities sum to at most 0.4, with fair random bits. Over 4096 cycles the density of `sum_bit` lies within 0.06 of the sum of the input densities.
- R7: The input count N_IN is fixed at elaboration to a value from 2 to 8, and GAP to at least 2. Other values stop elaboration.
- R8: If any input bit is 1 while its `rnd_half` bit is 0, `sum_bit` is 1 in the next cycle. An input stream of constant ones with its random bit held low therefore drives the output to constant ones, which is the saturated result for sums of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bits | input | N_IN | One stochastic bit per addend stream |
| rnd_half | input | N_IN | Fair random bit per input, halves the squared term of the exp stage |
| rnd_log | input | 1 | Fair random bit, halves the squared term of the log stage |
| sum_bit | output | 1 | Output stochastic stream carrying the approximate sum |

## Verification
The condition hardest to reach from the ports is the log stage's squared term. It needs z to have been 1 both GAP and 2·GAP cycles back, with `rnd_log` high in the current cycle, and it only shows when the current z is 0. Random inputs at moderate densities produce this case many times within each 4096-cycle run. A cycle-exact model, which keeps its own input history and z history, then checks every output bit. A separate phase holds one input at 1 with its random bit high after a quiet stretch. This exercises the path where the delayed copy keeps the mapped bit at 1, and checks that the one-cycle pulse at the start ends.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
   localparam int N_IN_MIN = 2;
   localparam int N_IN_MAX = 8;
   localparam int GAP_MIN  = 2;

   // length of the z delay line needed for two independent delayed copies
   function automatic int hist_len(input int gap);
      return 2 * gap;
   endfunction
endpackage

// File: rtl/sadd_exp_map.sv
// Maps one stream of density x to a stream of density 1 - x + x^2/2.
module sadd_exp_map (
   input  logic clk,
   input  logic rst_n,
   input  logic x_in,
   input  logic rnd_half,
   output logic e_out
);
   logic x_prev;   // delayed copy, independent of x_in for an iid stream
   logic sq_half;  // density x^2/2 when ANDed with x_in

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) x_prev <= 1'b0;
      else        x_prev <= x_in;
   end

   assign sq_half = x_prev & rnd_half;
   // P(x AND NOT sq_half) = x - x^2/2 ; complement gives 1 - x + x^2/2
   assign e_out   = ~(x_in & ~sq_half);

   // R2: an input held high with the random bit high keeps the mapped bit high
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in && $past(x_in) && rnd_half) |-> e_out);
   // R2: a low input never clears the mapped bit
   p_low_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_in) |-> e_out);
endmodule

// File: rtl/sadd_log_map.sv
// Maps a stream of density z = 1 - y to approximately -log(y) = z + z^2/2.
module sadd_log_map #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic z_in,
   input  logic rnd_sel,
   output logic sum_o
);
   localparam int HL = sadd_pkg::hist_len(GAP);

   logic [HL-1:0] z_hist;   // z_hist[k] holds z from k+1 cycles ago
   logic          z_near;
   logic          z_far;
   logic          sq_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_hist <= '0;
      else        z_hist <= {z_hist[HL-2:0], z_in};
   end

   assign z_near  = z_hist[GAP-1];
   assign z_far   = z_hist[HL-1];
   assign sq_term = z_near & z_far & rnd_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_o <= 1'b0;
      else        sum_o <= z_in | sq_term;
   end

   // R4: a set complement bit always reaches the output one cycle later
   p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      z_in |=> sum_o);
   // R4: without the random select, only the current complement bit counts
   p_sel_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!z_in && !rnd_sel) |=> !sum_o);
endmodule

// File: rtl/sadd_exp_top.sv
module sadd_exp_top #(
   parameter int N_IN = 4,
   parameter int GAP  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] in_bits,
   input  logic [N_IN-1:0] rnd_half,
   input  logic            rnd_log,
   output logic            sum_bit
);
   localparam int QUIET_MAX = sadd_pkg::hist_len(GAP);
   localparam int QW        = $clog2(QUIET_MAX + 1) + 1;

   // R7: elaboration-time parameter checks
   generate
      if (N_IN < sadd_pkg::N_IN_MIN || N_IN > sadd_pkg::N_IN_MAX) begin : g_bad_n
         $error("sadd_exp_top: N_IN out of range");
      end
      if (GAP < sadd_pkg::GAP_MIN) begin : g_bad_gap
         $error("sadd_exp_top: GAP too small");
      end
   endgenerate

   logic [N_IN-1:0] e_vec;
   logic            prod;
   logic            z_bit;

   generate
      for (genvar gi = 0; gi < N_IN; gi++) begin : g_map
         sadd_exp_map i_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .x_in     (in_bits[gi]),
            .rnd_half (rnd_half[gi]),
            .e_out    (e_vec[gi])
         );
      end
   endgenerate

   // product of exp(-x_i) densities gives exp(-sum)
   assign prod  = &e_vec;
   assign z_bit = ~prod;

   sadd_log_map #(.GAP(GAP)) i_log (
      .clk     (clk),
      .rst_n   (rst_n),
      .z_in    (z_bit),
      .rnd_sel (rnd_log),
      .sum_o   (sum_bit)
   );

   // cycles of all-zero input seen so far, saturating; used by the R5 check
   logic [QW-1:0] quiet_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      quiet_cnt <= QW'(QUIET_MAX);
      else if (in_bits != '0)          quiet_cnt <= '0;
      else if (quiet_cnt < QW'(QUIET_MAX)) quiet_cnt <= quiet_cnt + 1'b1;
   end

   // R1: output held low during reset
   p_reset_r1: assert property (@(posedge clk) (!rst_n) |-> !sum_bit);
   // R5: a long enough quiet stretch forces a zero output
   p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt == QW'(QUIET_MAX) && in_bits == '0) |=> !sum_bit);
   // R8: an unmasked high input saturates the next output bit
   p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(in_bits & ~rnd_half)) |=> sum_bit);
   // R3: any high input with all random bits low makes the complement bit high
   p_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bits != '0 && rnd_half == '0) |-> z_bit);
endmodule

// File: tb/test_sadd_exp_top.sv
`timescale 1ns/1ps
module test_sadd_exp_top;
   localparam int N  = 4;
   localparam int G  = 2;
   localparam int HL = 2 * G;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] in_bits = '0;
   logic [N-1:0] rnd_half = '0;
   logic         rnd_log = 1'b0;
   logic         sum_bit;

   int  checks = 0;
   int  errors = 0;
   int  ones = 0;
   bit  done = 0;

   // reference model state
   bit [N-1:0]  m_prev_x = '0;
   bit [HL-1:0] m_zh = '0;

   always #5 clk = ~clk;

   sadd_exp_top #(.N_IN(N), .GAP(G)) i_sadd_exp_top (
      .clk(clk), .rst_n(rst_n), .in_bits(in_bits),
      .rnd_half(rnd_half), .rnd_log(rnd_log), .sum_bit(sum_bit)
   );

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit pbit(input int milli);
      return ($urandom % 1000) < milli;
   endfunction

   // drive one cycle of stimulus, predict, then check at the next negedge
   task automatic run_cycle(input bit [N-1:0] x, input bit [N-1:0] r,
                            input bit rl, input string tag);
      bit z = 0;
      bit expv;
      for (int i = 0; i < N; i++) begin
         bit e = !(x[i] && !(m_prev_x[i] && r[i]));
         if (!e) z = 1;
      end
      expv = z | (m_zh[G-1] & m_zh[HL-1] & rl);
      m_prev_x = x;
      m_zh = {m_zh[HL-2:0], z};
      in_bits = x; rnd_half = r; rnd_log = rl;
      @(negedge clk);
      if (sum_bit === 1'b1) ones++;
      check_bit(tag, sum_bit, expv);
   endtask

   task automatic density_run(input int p0, input int p1, input int p2, input int p3);
      int p [N];
      int sum_m;
      int got_m;
      int diff;
      p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
      sum_m = p0 + p1 + p2 + p3;
      if (sum_m > 1000) sum_m = 1000;
      ones = 0;
      for (int c = 0; c < 4096; c++) begin
         bit [N-1:0] x;
         bit [N-1:0] r;
         for (int i = 0; i < N; i++) begin
            x[i] = pbit(p[i]);
            r[i] = pbit(500);
         end
         run_cycle(x, r, pbit(500), "R4 cycle");
      end
      got_m = (ones * 1000) / 4096;
      diff = got_m - sum_m;
      if (diff < 0) diff = -diff;
      checks++;
      if (diff > 60) begin
         errors++;
         $display("FAIL R6 density actual=%0d/1000 expected=%0d/1000", got_m, sum_m);
      end
   endtask

   initial begin
      // R7: instance parameters inside the allowed range
      checks++;
      if (N < 2 || N > 8 || G < 2) begin
         errors++;
         $display("FAIL R7 params actual=%0d,%0d expected=2..8,>=2", N, G);
      end

      // R1: outputs held low under reset even with busy inputs
      in_bits = '1; rnd_log = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check_bit("R1 reset", sum_bit, 1'b0);
      end
      in_bits = '0; rnd_log = 1'b0;
      rst_n = 1'b1;

      // R5: quiet inputs with noisy random bits give zero output
      for (int k = 0; k < 10; k++)
         run_cycle('0, N'($urandom), pbit(500), "R5 quiet");

      // R2: input 0 held high with its random bit high: one pulse, then low
      for (int k = 0; k < 8; k++)
         run_cycle(N'(1), N'(1), 1'b0, "R2 hold");
      for (int k = 0; k < 8; k++)
         run_cycle('0, '0, 1'b1, "R5 drain");

      // R8 / R3: an unmasked constant input saturates the output
      for (int k = 0; k < 12; k++)
         run_cycle(N'(4), '0, pbit(500), "R8 saturate");
      for (int k = 0; k < 12; k++)
         run_cycle(N'($urandom) | N'(1), {N{1'b0}}, 1'b1, "R3 any-kill");

      // R6 / R4: density checks with cycle-exact comparison
      density_run(100, 100, 100, 100);
      density_run(300, 0, 0, 0);
      density_run(50, 50, 100, 0);
      density_run(0, 0, 0, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule